// File: doc/BRIEF.md
# Single-Cycle 16-bit Accumulator Processor Core

This block is a small processor core for a machine that keeps program and data in separate memories. Each clock cycle it takes one 16-bit instruction word and one 16-bit word read from data memory. It updates two internal registers: an address/pointer register and a data accumulator. In the same cycle it drives a data-memory write port and advances a 15-bit program counter. Instruction storage, data storage and any memory-mapped peripherals sit outside the block.

There are two kinds of instruction, and the most significant bit tells them apart. An address load places the whole word in the address register. A compute instruction does four things:
- it picks the ALU's second operand, either the address register or the memory read word;
- it sets six ALU control bits;
- it writes the result to any mix of the address register, the accumulator and data memory;
- it may branch to the address held in the address register, based on the sign and zero state of the result.

The memory write port is combinational from the current instruction, so a store completes in the same cycle. The register and program-counter updates land on the next rising clock edge.

Top module: `cpu16_core`

## Requirements
- R1: While `rst` is high, `mem_we` is 0. A rising edge with `rst` high clears the program counter, the address register and the accumulator to 0.
- R2: A word with bit 15 = 0 is an address load. After the edge the address register holds the whole word, the accumulator is unchanged, and `mem_we` is 0 during that cycle.
- R3: In a compute word (bit 15 = 1), bits 14:13 are ignored. Bit 12 selects the ALU's y operand: 1 takes `mem_rdata`, 0 takes the address register. The x operand is always the accumulator.
- R4: Bits 11:6 are the ALU controls, from bit 11 down: clear x, invert x, clear y, invert y, function (1 = add, 0 = bitwise AND), invert output. They are applied in that order. Addition wraps modulo 2^16.
- R5: Bits 5:3 choose destinations: bit 5 the address register, bit 4 the accumulator, bit 3 data memory. Every selected destination receives the result in the same cycle. An unselected register keeps its value.
- R6: With bit 3 set in a compute word, `mem_we` is 1 in that cycle, `mem_wdata` carries the ALU result, and `mem_addr` carries the address register's low 15 bits as they stood before the edge.
- R7: Bits 2:0 are the branch mask: bit 2 on negative, bit 1 on zero, bit 0 on positive (result nonzero and bit 15 clear). If any selected condition matches the result, the program counter loads the low 15 bits of the address register as it stood before the edge.
- R8: Otherwise the program counter increments by 1 each edge and wraps from 32767 to 0.
- R9: Reset overrides a taken branch, and a taken branch overrides the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word fetched at `pc_o` |
| mem_rdata | input | 16 | Data memory word read at `mem_addr` |
| mem_wdata | output | 16 | Value to store in data memory |
| mem_we | output | 1 | Data memory write enable |
| mem_addr | output | 15 | Data memory address (address register) |
| pc_o | output | 15 | Program counter: address of the instruction to run |

## Verification
The store port (`mem_we`, `mem_wdata`, `mem_addr`) is due in the same cycle as the instruction that causes it. Register and program-counter effects appear only after the following rising edge. The bench applies each instruction at a falling edge and compares all four outputs 5 ns later. At that point the port values come from the current word, and `pc_o` and `mem_addr` reflect the state left by the previous edge. Effects on the accumulator and on the address register are therefore checked one instruction later, through the next store or branch. The reference model in the scoreboard advances only after the rising edge.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 15;
    localparam int OP_BIT = WORD_W - 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic {
        OP_ALOAD   = 1'b0,
        OP_COMPUTE = 1'b1
    } opcode_e;

    // Packed order matches instruction bits 11:6.
    typedef struct packed {
        logic clr_x;
        logic inv_x;
        logic clr_y;
        logic inv_y;
        logic add_f;
        logic inv_o;
    } alu_ctl_t;

    // Packed order matches instruction bits 5:3.
    typedef struct packed {
        logic to_a;
        logic to_d;
        logic to_m;
    } dest_t;

    // Packed order matches instruction bits 2:0.
    typedef struct packed {
        logic on_neg;
        logic on_zero;
        logic on_pos;
    } jump_t;

    typedef struct packed {
        opcode_e  op;
        logic     y_mem;
        alu_ctl_t ctl;
        dest_t    dest;
        jump_t    jump;
        word_t    imm;
    } decoded_t;

    typedef struct packed {
        word_t value;
        logic  zero;
        logic  neg;
    } alu_res_t;

    function automatic logic branch_met(jump_t j, logic zero, logic neg);
        logic pos;
        pos = !zero && !neg;
        return (j.on_neg && neg) || (j.on_zero && zero) || (j.on_pos && pos);
    endfunction

endpackage

// File: rtl/cpu16_decode.sv
module cpu16_decode
    import cpu16_pkg::*;
(
    input  word_t    instr,
    output decoded_t dec
);
    always_comb begin
        dec.op    = opcode_e'(instr[OP_BIT]);
        dec.y_mem = instr[12];
        dec.ctl   = alu_ctl_t'(instr[11:6]);
        dec.imm   = instr;
        if (dec.op == OP_COMPUTE) begin
            dec.dest = dest_t'(instr[5:3]);
            dec.jump = jump_t'(instr[2:0]);
        end else begin
            dec.dest = '0;
            dec.jump = '0;
        end
    end
endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
(
    input  word_t    x_in,
    input  word_t    y_in,
    input  alu_ctl_t ctl,
    output alu_res_t res
);
    word_t x0, x1, y0, y1, f_out, o_val;

    always_comb begin
        x0    = ctl.clr_x ? '0 : x_in;
        x1    = ctl.inv_x ? ~x0 : x0;
        y0    = ctl.clr_y ? '0 : y_in;
        y1    = ctl.inv_y ? ~y0 : y0;
        f_out = ctl.add_f ? (x1 + y1) : (x1 & y1);
        o_val = ctl.inv_o ? ~f_out : f_out;
        res.value = o_val;
        res.zero  = (o_val == '0);
        res.neg   = o_val[WORD_W-1];
    end

    // R4: with both operands cleared and plain AND, the result is zero
    always_comb begin
        if (ctl.clr_x && ctl.clr_y && !ctl.inv_x && !ctl.inv_y && !ctl.inv_o)
            alu_zero_chk: assert (res.zero);
    end
endmodule

// File: rtl/cpu16_pc.sv
module cpu16_pc
    import cpu16_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);
    localparam logic [AW-1:0] PC_ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else if (load)
            pc <= target;
        else
            pc <= pc + PC_ONE;
    end

    // R9
    pc_reset_chk: assert property (@(posedge clk) rst |=> pc == '0);

    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> pc == $past(pc) + PC_ONE);

    // R7
    pc_jump_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> pc == $past(target));
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
    import cpu16_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] instr_i,
    input  logic [15:0] mem_rdata,
    output logic [15:0] mem_wdata,
    output logic        mem_we,
    output logic [14:0] mem_addr,
    output logic [14:0] pc_o
);
    decoded_t dec;
    alu_res_t alu_r;
    word_t    a_q, d_q, y_sel;
    logic     take;

    cpu16_decode u_dec (
        .instr (instr_i),
        .dec   (dec)
    );

    always_comb y_sel = dec.y_mem ? mem_rdata : a_q;

    cpu16_alu u_alu (
        .x_in (d_q),
        .y_in (y_sel),
        .ctl  (dec.ctl),
        .res  (alu_r)
    );

    always_comb take = branch_met(dec.jump, alu_r.zero, alu_r.neg);

    cpu16_pc #(.AW(ADDR_W)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .load   (take),
        .target (a_q[ADDR_W-1:0]),
        .pc     (pc_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            d_q <= '0;
        end else if (dec.op == OP_ALOAD) begin
            a_q <= dec.imm;
        end else begin
            if (dec.dest.to_a) a_q <= alu_r.value;
            if (dec.dest.to_d) d_q <= alu_r.value;
        end
    end

    assign mem_we    = !rst && dec.dest.to_m;
    assign mem_wdata = alu_r.value;
    assign mem_addr  = a_q[ADDR_W-1:0];

    // R2
    aload_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_i[15] |=> a_q == $past(instr_i));

    // R2
    aload_nowr_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_i[15] |-> !mem_we);

    // R5
    d_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_i[15] && !instr_i[4]) |=> d_q == $past(d_q));

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (a_q == '0 && d_q == '0));
endmodule

// File: tb/tb_cpu16_core.sv
module tb_cpu16_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr_i = '0;
    logic [15:0] mem_rdata;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [14:0] mem_addr;
    logic [14:0] pc_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cpu16_core dut (
        .clk(clk), .rst(rst), .instr_i(instr_i), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_addr(mem_addr), .pc_o(pc_o)
    );

    // Environment data RAM, written by the design
    logic [15:0] ram [64];
    initial for (int i = 0; i < 64; i++) ram[i] = '0;
    assign mem_rdata = ram[mem_addr[5:0]];
    always @(posedge clk) if (mem_we) ram[mem_addr[5:0]] <= mem_wdata;

    // Reference state
    logic [15:0] m_a, m_d;
    logic [14:0] m_pc;
    logic [15:0] exp_ram [64];
    initial for (int i = 0; i < 64; i++) exp_ram[i] = '0;

    typedef struct {
        logic [14:0] pc;
        logic        we;
        logic [14:0] addr;
        logic [15:0] wdata;
        string       tag;
    } exp_t;
    exp_t q[$];
    event ev_cmp;

    localparam logic [6:0] C_ZERO = 7'b0101010, C_ONE = 7'b0111111,
        C_D = 7'b0001100, C_A = 7'b0110000, C_DP1 = 7'b0011111,
        C_DM1 = 7'b0001110, C_MP1 = 7'b1110111, C_DMA = 7'b0010011,
        C_DORA = 7'b0010101, C_NEG1 = 7'b0111010, C_M = 7'b1110000;
    localparam logic [2:0] J_NO = 3'b000, J_GT = 3'b001, J_EQ = 3'b010,
        J_GE = 3'b011, J_LT = 3'b100, J_NE = 3'b101, J_LE = 3'b110, J_MP = 3'b111;
    localparam logic [2:0] D_NO = 3'b000, D_M = 3'b001, D_D = 3'b010,
        D_MD = 3'b011, D_AMD = 3'b111;

    function automatic logic [15:0] ai(input int v);
        return {1'b0, 15'(v)};
    endfunction
    function automatic logic [15:0] ci(input logic [6:0] c, input logic [2:0] d, input logic [2:0] j);
        return {3'b111, c, d, j};
    endfunction
    function automatic logic [15:0] ref_alu(input logic [15:0] x, input logic [15:0] y, input logic [5:0] c);
        logic [15:0] r;
        if (c[5]) x = '0;
        if (c[4]) x = ~x;
        if (c[3]) y = '0;
        if (c[2]) y = ~y;
        r = c[1] ? x + y : x & y;
        if (c[0]) r = ~r;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic model_reset();
        m_a = '0; m_d = '0; m_pc = '0;
    endtask

    // Driver: applies one word, pushes expectation, advances the model
    task automatic step(input logic [15:0] ins, input string tag);
        exp_t e;
        logic [15:0] y, r;
        logic take;
        @(negedge clk);
        instr_i = ins;
        y = ins[12] ? exp_ram[m_a[5:0]] : m_a;
        r = ref_alu(m_d, y, ins[11:6]);
        e.pc = m_pc; e.addr = m_a[14:0]; e.wdata = r; e.tag = tag;
        e.we = ins[15] && ins[3];
        q.push_back(e);
        -> ev_cmp;
        @(posedge clk); #1;
        if (!ins[15]) begin
            m_a = ins;
            m_pc = m_pc + 15'd1;
        end else begin
            take = (ins[2] && r[15]) || (ins[1] && r == 0) || (ins[0] && r != 0 && !r[15]);
            if (ins[3]) exp_ram[m_a[5:0]] = r;
            m_pc = take ? m_a[14:0] : m_pc + 15'd1;
            if (ins[4]) m_d = r;
            if (ins[5]) m_a = r;
        end
    endtask

    // Monitor
    initial begin
        forever begin
            exp_t e;
            @(ev_cmp);
            #5;
            e = q.pop_front();
            check(pc_o == e.pc, {e.tag, " pc"}, pc_o, e.pc);
            check(mem_we == e.we, {e.tag, " we"}, mem_we, e.we);
            if (e.we) begin
                check(mem_addr == e.addr, {e.tag, " addr"}, mem_addr, e.addr);
                check(mem_wdata == e.wdata, {e.tag, " wdata"}, mem_wdata, e.wdata);
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 / R9: reset with a store and a jump presented
        instr_i = ci(C_ONE, D_M, J_MP);
        @(negedge clk); @(negedge clk); #5;
        check(mem_we == 1'b0, "R1 we in reset", mem_we, 0);
        check(pc_o == 15'd0, "R9 pc in reset", pc_o, 0);
        @(negedge clk);
        rst = 1'b0;
        model_reset();

        step(ai(5),                    "R2 load 5");
        step(ci(C_A, D_D, J_NO),       "R3 D=A");
        step(ai(20),                   "R2 load 20");
        step(ci(C_DP1, D_M, J_NO),     "R6 M=D+1");
        step(ci(C_DM1, D_MD, J_NO),    "R5 MD=D-1");
        step(ci(C_MP1, D_D, J_NO),     "R3 D=M+1");
        step(ci(C_M, D_M, J_NO),       "R3 M=M");
        step(ai(10),                   "R2 load 10");
        step(ci(C_DMA, D_NO, J_LT),    "R7 JLT");
        step(ci(C_DORA, D_AMD, J_NO),  "R5 AMD");
        step(ai(13),                   "R2");
        step(ci(C_D, D_NO, J_EQ),      "R7 JEQ not");
        step(ci(C_ZERO, D_D, J_NO),    "R4 D=0");
        step(ai(17),                   "R2");
        step(ci(C_D, D_NO, J_EQ),      "R7 JEQ taken");
        step(ai(19),                   "R2");
        step(ci(C_D, D_NO, J_GT),      "R7 JGT not");
        step(ai(21),                   "R2");
        step(ci(C_DM1, D_NO, J_NE),    "R7 JNE");
        step(ci(C_D, D_NO, J_LE),      "R7 JLE");
        step(ci(C_NEG1, D_D, J_GE),    "R7 JGE not");
        step(ai(30),                   "R2");
        step(ci(C_D, D_M, J_GT),       "R6 M=D -1");
        step({3'b100, C_ONE, D_D, J_NO}, "R3 ignored bits");
        step(ai(32767),                "R2");
        step(ci(C_ZERO, D_NO, J_MP),   "R7 JMP");
        step(ci(C_D, D_NO, J_NO),      "R8 wrap");
        step(ci(C_D, D_NO, J_NO),      "R8 after wrap");

        // R9: reset over a taken jump mid-run
        @(negedge clk);
        rst = 1'b1;
        instr_i = ci(C_ZERO, D_NO, J_MP);
        @(negedge clk); #5;
        check(pc_o == 15'd0, "R9 reset beats jump", pc_o, 0);
        rst = 1'b0;
        model_reset();
        step(ci(C_DP1, D_D, J_NO),     "R1 D cleared");
        step(ai(40),                   "R2");
        step(ci(C_D, D_M, J_NO),       "R1 store D");

        @(negedge clk); #5;
        for (int k = 0; k < 64; k++)
            if (k == 10 || k == 20 || k == 30 || k == 40)
                check(ram[k] == exp_ram[k], "R6 ram content", ram[k], exp_ram[k]);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule